// File: doc/BRIEF.md
# Asynchronous SRAM Pin-Level Emulator

This block is a synthesizable, clock-sampled stand-in for a byte-wide asynchronous static RAM. The three active-low control pins (select, output enable, write enable), the address and the input data are all sampled on the rising edge of the system clock. Each sample is decoded into one of four modes: deselected, output off, read or write.

Writes are tracked across the window in which select and write enable are both low. The word is committed when that window closes. The tristate data pins are split into a data-out bus and a registered drive-enable, so that a memory-controller testbench can treat the block as the external part. A violation pulse reports any address change inside a write window.

The array depth is set by `ADDR_W`. A value of 15 gives the full 32K x 8 organisation. The default is kept small so that the block elaborates quickly.

Top module: `sram_emu`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits. A committed word stays in place until it is overwritten, and a later read of its address returns it.
- R2: A sample with cs_n_i high makes drive_o 0 after that edge, whatever oe_n_i and we_n_i are. Whenever drive_o is 0, dout_o reads all zeros.
- R3: A sample with cs_n_i low and both oe_n_i and we_n_i high makes drive_o 0 after that edge.
- R4: A sample with cs_n_i low and we_n_i low is a write sample. drive_o is 0 after it even when oe_n_i is low, and a low oe_n_i does not stop the write.
- R5: A read sample is one with cs_n_i low, oe_n_i low and we_n_i high, outside the condition of R7. After a read sample, drive_o is 1 and dout_o holds the word stored at the address sampled at that edge.
- R6: A write window is a run of one or more consecutive write samples. It commits at the first later sample where cs_n_i or we_n_i is high. The address used is the one sampled at the first sample of the window. The data used is din_i from the last sample of the window.
- R7: Suppose cs_n_i goes from high to low at a sample where we_n_i is already low, or falls at that same sample. Then drive_o stays 0 at every sample until cs_n_i is sampled high again, even if we_n_i returns high with oe_n_i low.
- R8: addr_viol_o is 1 for exactly one cycle after each write sample that follows another write sample of the same window and carries a different address from the one captured for the window. Otherwise addr_viol_o is 0.
- R9: A read sample that coincides with the commit of a window to the same address returns the newly committed word.
- R10: While rst is high and after its release, drive_o and addr_viol_o are 0 and no write is pending. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address |
| cs_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| din_i | input | DATA_W | Data presented on the pins by the controller |
| dout_o | output | DATA_W | Data the part would drive, zero when not driving |
| drive_o | output | 1 | Registered pin drive enable, stands in for the tristate control |
| addr_viol_o | output | 1 | One-cycle pulse on an address change inside a write window |

## Verification
The hardest case to produce is the select-late write of R7. Write enable must already be low, or fall together with select, when select drops. Write enable must then be released while output enable is low and select is held. Only then does the block's choice to keep the pins quiet show, instead of the read that the raw pin levels would suggest.

The bench builds that sequence directly. It places it next to the opposite ordering, where select falls first, which must drive again with the new word through the same-edge bypass of R9. Both cases run over a small array that is first filled and read back in full, once with each write ordering.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_QUIET = 2'd1,
    M_READ  = 2'd2,
    M_WRITE = 2'd3
  } pin_mode_t;
endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
  import sram_emu_pkg::*;
(
  input  logic      cs_n,
  input  logic      oe_n,
  input  logic      we_n,
  output pin_mode_t mode
);
  // write enable outranks output enable; select outranks both
  always_comb begin
    if (cs_n)       mode = M_IDLE;
    else if (!we_n) mode = M_WRITE;
    else if (!oe_n) mode = M_READ;
    else            mode = M_QUIET;
  end
endmodule

// File: rtl/sram_wr_track.sv
module sram_wr_track
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pin_mode_t         mode,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [DATA_W-1:0] cm_data_o,
  output logic              viol_o
);
  logic              ovl;
  logic              in_wr_q;
  logic              viol_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [DATA_W-1:0] hold_data_q;

  assign ovl = (mode == M_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_wr_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      in_wr_q <= ovl;
      viol_q  <= in_wr_q && ovl && (addr_i != hold_addr_q);
    end
    // address fixed at the opening sample, data follows the last sample
    if (ovl && !in_wr_q) hold_addr_q <= addr_i;
    if (ovl)             hold_data_q <= din_i;
  end

  assign commit_o  = in_wr_q && !ovl;
  assign cm_addr_o = hold_addr_q;
  assign cm_data_o = hold_data_q;
  assign viol_o    = viol_q;
endmodule

// File: rtl/sram_cell_array.sv
module sram_cell_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // simple dual-port, read-first: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/sram_emu.sv
module sram_emu
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              drive_o,
  output logic              addr_viol_o
);
  pin_mode_t         mode;
  logic              commit;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data;
  logic [DATA_W-1:0] rd_data;
  logic              cs_prev_q;
  logic              blk_q;
  logic              blk_next;
  logic              drive_q;
  logic              byp_q;
  logic [DATA_W-1:0] byp_data_q;

  sram_mode_dec u_dec (
    .cs_n (cs_n_i),
    .oe_n (oe_n_i),
    .we_n (we_n_i),
    .mode (mode)
  );

  sram_wr_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .addr_i    (addr_i),
    .din_i     (din_i),
    .commit_o  (commit),
    .cm_addr_o (cm_addr),
    .cm_data_o (cm_data),
    .viol_o    (addr_viol_o)
  );

  sram_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .wr_en   (commit),
    .wr_addr (cm_addr),
    .wr_data (cm_data),
    .rd_addr (addr_i),
    .rd_data (rd_data)
  );

  // select falling onto an already-low write enable silences the pins
  // until select is released
  assign blk_next = !cs_n_i && (blk_q || (!we_n_i && cs_prev_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev_q <= 1'b1;
      blk_q     <= 1'b0;
      drive_q   <= 1'b0;
      byp_q     <= 1'b0;
    end else begin
      cs_prev_q <= cs_n_i;
      blk_q     <= blk_next;
      drive_q   <= (mode == M_READ) && !blk_next;
      byp_q     <= commit && (cm_addr == addr_i);
    end
    byp_data_q <= cm_data;
  end

  assign drive_o = drive_q;
  assign dout_o  = drive_q ? (byp_q ? byp_data_q : rd_data) : '0;
endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic oe_n,
  input logic we_n,
  input logic drive,
  input logic viol
);
  p_desel_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !drive);

  p_out_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && oe_n && we_n) |=> !drive);

  p_no_drive_in_write_r4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !we_n) |=> !drive);

  p_read_drives_r5: assert property (@(posedge clk) disable iff (rst)
    (cs_n ##1 (!cs_n && !oe_n && we_n)) |=> drive);

  p_late_select_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (cs_n ##1 (!cs_n && !we_n) ##1 !cs_n) |=> !drive);

  p_viol_in_window_r8: assert property (@(posedge clk) disable iff (rst)
    viol |-> ($past(!cs_n && !we_n, 1) && $past(!cs_n && !we_n, 2)));

  p_reset_clear_r10: assert property (@(posedge clk)
    $past(rst) |-> (!drive && !viol));
endmodule

bind sram_emu sram_emu_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .cs_n  (cs_n_i),
  .oe_n  (oe_n_i),
  .we_n  (we_n_i),
  .drive (drive_o),
  .viol  (addr_viol_o)
);

// File: tb/sram_emu_tb.sv
module sram_emu_tb;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          cs_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          we_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          drive;
  logic          viol;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [N];

  always #5 clk = ~clk;

  sram_emu #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (addr),
    .cs_n_i      (cs_n),
    .oe_n_i      (oe_n),
    .we_n_i      (we_n),
    .din_i       (din),
    .dout_o      (dout),
    .drive_o     (drive),
    .addr_viol_o (viol)
  );

  function automatic logic [DW-1:0] pat(input int a, input int p);
    return DW'((a * 37 + p * 11 + 5) & 8'hFF);
  endfunction

  task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one sample; outputs are looked at 1 ns after the edge
  task automatic step(input logic c, input logic o, input logic w,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cs_n = c; oe_n = o; we_n = w; addr = a; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    step(1'b0, 1'b0, 1'b1, a, '0);
    chk(req, {drive, dout}, {1'b1, model[a]});
  endtask

  task automatic idle_chk(input string req);
    step(1'b1, 1'b1, 1'b1, '0, '0);
    chk(req, {drive, dout}, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R10", {drive, dout}, '0);
    chk("R10", {8'h00, viol}, '0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R10", {drive, dout}, '0);

    // R1/R6: fill via select-first windows (single-sample overlap)
    for (int a = 0; a < N; a++) begin
      step(1'b0, 1'b1, 1'b1, AW'(a), '0);
      step(1'b0, 1'b1, 1'b0, AW'(a), pat(a, 0));
      chk("R4", {drive, dout}, '0);
      step(1'b1, 1'b1, 1'b1, AW'(a), '0);
      model[a] = pat(a, 0);
    end
    for (int a = 0; a < N; a++) rd(AW'(a), "R1");

    // R4/R6: write-enable-first windows, oe low throughout
    for (int a = 0; a < N; a++) begin
      step(1'b1, 1'b0, 1'b0, AW'(a), pat(a, 1));
      chk("R2", {drive, dout}, '0);
      step(1'b0, 1'b0, 1'b0, AW'(a), pat(a, 1));
      chk("R4", {drive, dout}, '0);
      step(1'b1, 1'b0, 1'b1, AW'(a), '0);
      chk("R2", {drive, dout}, '0);
      model[a] = pat(a, 1);
    end
    for (int a = N - 1; a >= 0; a--) rd(AW'(a), "R1");

    // R2/R3/R4/R5: every control combination after a deselected sample
    for (int m = 0; m < 8; m++) begin
      logic c, o, w, e;
      c = m[2]; o = m[1]; w = m[0];
      e = !c && !o && w;
      step(1'b1, 1'b1, 1'b1, 6'd9, '0);
      step(c, o, w, 6'd9, model[9]);
      if (e) chk("R5", {drive, dout}, {1'b1, model[9]});
      else if (c) chk("R2", {drive, dout}, '0);
      else if (!w) chk("R4", {drive, dout}, '0);
      else chk("R3", {drive, dout}, '0);
    end
    idle_chk("R2");

    // R6: last sampled data wins
    step(1'b0, 1'b1, 1'b1, 6'd20, '0);
    step(1'b0, 1'b1, 1'b0, 6'd20, 8'h11);
    step(1'b0, 1'b1, 1'b0, 6'd20, 8'h22);
    step(1'b0, 1'b1, 1'b0, 6'd20, 8'h33);
    step(1'b0, 1'b1, 1'b1, 6'd20, 8'h44);
    model[20] = 8'h33;
    idle_chk("R6");
    rd(6'd20, "R6");

    // R8/R6: address moves inside a window
    idle_chk("R8");
    step(1'b0, 1'b1, 1'b1, 6'd5, '0);
    step(1'b0, 1'b1, 1'b0, 6'd5, 8'hAA);
    chk("R8", {8'h00, viol}, '0);
    step(1'b0, 1'b1, 1'b0, 6'd6, 8'hBB);
    chk("R8", {8'h00, viol}, 9'h001);
    step(1'b0, 1'b1, 1'b0, 6'd6, 8'hCC);
    chk("R8", {8'h00, viol}, 9'h001);
    step(1'b0, 1'b1, 1'b0, 6'd5, 8'hDD);
    chk("R8", {8'h00, viol}, '0);
    step(1'b1, 1'b1, 1'b1, 6'd5, '0);
    chk("R8", {8'h00, viol}, '0);
    model[5] = 8'hDD;
    rd(6'd5, "R6");
    rd(6'd6, "R6");

    // R7: select falls after write enable, then write enable released
    idle_chk("R7");
    step(1'b1, 1'b0, 1'b0, 6'd30, 8'h5A);
    step(1'b0, 1'b0, 1'b0, 6'd30, 8'h5A);
    chk("R7", {drive, dout}, '0);
    step(1'b0, 1'b0, 1'b1, 6'd30, '0);
    chk("R7", {drive, dout}, '0);
    step(1'b0, 1'b0, 1'b1, 6'd30, '0);
    chk("R7", {drive, dout}, '0);
    model[30] = 8'h5A;
    idle_chk("R7");
    rd(6'd30, "R7");

    // R7: select and write enable fall on the same sample
    idle_chk("R7");
    step(1'b0, 1'b0, 1'b0, 6'd31, 8'hA5);
    chk("R7", {drive, dout}, '0);
    step(1'b0, 1'b0, 1'b1, 6'd31, '0);
    chk("R7", {drive, dout}, '0);
    model[31] = 8'hA5;
    idle_chk("R7");
    rd(6'd31, "R7");

    // R9: select first, read, write, release write enable -> new word
    idle_chk("R9");
    rd(6'd40, "R9");
    step(1'b0, 1'b0, 1'b0, 6'd40, 8'h3C);
    chk("R4", {drive, dout}, '0);
    step(1'b0, 1'b0, 1'b1, 6'd40, '0);
    chk("R9", {drive, dout}, {1'b1, 8'h3C});
    model[40] = 8'h3C;
    rd(6'd40, "R9");
    rd(6'd41, "R1");

    // R10: reset mid-window drops the pending write, keeps contents
    idle_chk("R10");
    step(1'b0, 1'b1, 1'b1, 6'd50, '0);
    step(1'b0, 1'b1, 1'b0, 6'd50, 8'hEE);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R10", {drive, viol, 7'h00}, '0);
    @(negedge clk); rst = 1'b0; cs_n = 1'b1; we_n = 1'b1;
    @(posedge clk); #1;
    rd(6'd50, "R10");
    rd(6'd0, "R10");

    idle_chk("R2");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule